// File: doc/BRIEF.md
# Lockable Identification Page Controller

This block sits behind a two-wire serial protocol engine and serves a separate 128-byte identification page that can be frozen once. The engine passes it framing events and whole bytes. Framing events are a start pulse and a stop pulse. Whole bytes come in two kinds: received bytes, and requests for the next byte to transmit. For each received byte the block decides whether it is acknowledged. It stages write data, and it keeps the page contents and a lock flag. Only a power-on reset clears the lock flag.

A select byte carries a 4-bit device code, then the three chip-select bits, then a direction bit. This block answers to device code 1011. In a write, the first address byte holds the bit that chooses the operation: bit 2, the address line A10. When that bit is 0 the transaction writes to the page. When it is 1 the transaction is a lock command or a lock-status probe. The low address byte gives the byte offset. Staged writes and a pending lock take effect only on a stop. At that stop the block issues one start pulse to the programming timer it shares with the main array. While the timer reports busy, the block refuses new selects.

Top module: `id_page_lock`

## Requirements
- R1: A received byte right after a start is a select byte. It is acknowledged only when bits 7:4 equal 1011 and bits 3:1 equal `chip_i`. Any other select byte gets NoACK. Every further byte until the next start or stop then gets NoACK and writes nothing.
- R2: While `prog_busy_i` is high, a matching select byte gets NoACK.
- R3: Write path: select with bit 0 = 0, then a high address byte with bit 2 = 0, then a low address byte. Bits 6:0 of the low byte set the offset. Other address bits are ignored. Both address bytes are acknowledged. While unlocked, each data byte is acknowledged and staged at the offset, and the offset then advances, wrapping from 127 to 0. A stop writes the staged bytes into the page. One cycle after that stop, `prog_start_o` is high for exactly one cycle.
- R4: A start that arrives before the stop discards all staged bytes and any pending lock. The following stop then raises no `prog_start_o`.
- R5: Lock command: high address byte with bit 2 = 1. While the page is unlocked, a data byte with bit 1 = 1 is acknowledged and arms the lock. The lock takes effect at the next stop, and `prog_start_o` pulses.
- R6: A lock data byte with bit 1 = 0 is acknowledged. It does not lock, and no `prog_start_o` follows.
- R7: Once the page is locked, every write data byte gets NoACK. The page keeps its contents and no `prog_start_o` follows.
- R8: Lock-status probe: the data byte after a lock-command address is acknowledged when the page is unlocked and gets NoACK when it is locked. A start sent after the probe cancels it.
- R9: The lock stays set whatever bus traffic follows. Only `rst_ni` clears it.
- R10: Read: a select with bit 0 = 1 is acknowledged. Each `rd_req_i` sets `rd_data_o` in the next cycle to the page byte at the current offset, then advances the offset, wrapping within 128. A read can start from an offset loaded by an earlier address phase. It can also continue from where the last access left the offset.
- R11: During reset, `ack_o`, `prog_start_o` and `rd_data_o` are 0, the page is all 0x00 and the lock is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| chip_i | input | 3 | Chip-select value this device answers to |
| start_i | input | 1 | Start condition seen (one-cycle pulse) |
| stop_i | input | 1 | Stop condition seen (one-cycle pulse) |
| byte_vld_i | input | 1 | A byte from the master is complete |
| byte_i | input | 8 | The received byte |
| rd_req_i | input | 1 | Engine needs the next byte to transmit |
| prog_busy_i | input | 1 | Shared programming timer is running |
| ack_o | output | 1 | 1 = ACK for the last received byte, 0 = NoACK |
| rd_data_o | output | 8 | Byte to transmit |
| prog_start_o | output | 1 | One-cycle request to start the programming timer |

## Verification
Nothing in the port list shows the lock. The bench reaches it in a fixed order. First comes a lock data byte with bit 1 clear, then a probe on the still unlocked page, then a real lock command closed by a stop. After that it uses probes and refused writes to show the lock is set. It then resets mid-run to show that only reset clears it. A transaction aborted by a repeated start is sent on purpose, and the bench checks both the missing timer pulse and the unchanged page byte. The wrap from offset 127 to 0 is reached by starting a write at 126.

// File: rtl/idp_pkg.sv
package idp_pkg;
  localparam logic [3:0] ID_DEV_CODE = 4'b1011;
  localparam int unsigned SEL_BIT = 2;  // A10 inside the high address byte
  localparam int unsigned ARM_BIT = 1;  // lock data byte key bit

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_LDAT,
    ST_RDAT,
    ST_IGN
  } idp_st_e;
endpackage

// File: rtl/idp_ctrl.sv
module idp_ctrl
  import idp_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 128,
  parameter int unsigned DW         = 8,
  localparam int unsigned OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       chip_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             byte_vld_i,
  input  logic [DW-1:0]    byte_i,
  input  logic             rd_req_i,
  input  logic             busy_i,
  input  logic             locked_i,
  output logic             ack_o,
  output logic [OFF_W-1:0] ptr_o,
  output logic             stg_we_o,
  output logic             lock_arm_o,
  output logic             commit_o,
  output logic             drop_o,
  output logic             rd_fire_o,
  output logic             sel_ph_o,
  output logic             wdat_ph_o
);
  idp_st_e          st_q, st_d;
  logic [OFF_W-1:0] ptr_q, ptr_d;
  logic             ack_q, ack_d;
  logic             a10_q, a10_d;

  always_comb begin
    st_d       = st_q;
    ptr_d      = ptr_q;
    ack_d      = ack_q;
    a10_d      = a10_q;
    stg_we_o   = 1'b0;
    lock_arm_o = 1'b0;
    rd_fire_o  = 1'b0;
    if (stop_i) begin
      st_d = ST_IDLE;
    end else if (start_i) begin
      st_d = ST_SEL;
    end else if (byte_vld_i) begin
      unique case (st_q)
        ST_SEL: begin
          if (byte_i[7:4] == ID_DEV_CODE && byte_i[3:1] == chip_i && !busy_i) begin
            ack_d = 1'b1;
            st_d  = byte_i[0] ? ST_RDAT : ST_AHI;
          end else begin
            ack_d = 1'b0;
            st_d  = ST_IGN;
          end
        end
        ST_AHI: begin
          ack_d = 1'b1;
          a10_d = byte_i[SEL_BIT];
          st_d  = ST_ALO;
        end
        ST_ALO: begin
          ack_d = 1'b1;
          ptr_d = byte_i[OFF_W-1:0];
          st_d  = a10_q ? ST_LDAT : ST_WDAT;
        end
        ST_WDAT: begin
          ack_d = !locked_i;
          if (!locked_i) begin
            stg_we_o = 1'b1;
            ptr_d    = ptr_q + 1'b1;
          end
        end
        ST_LDAT: begin
          ack_d      = !locked_i;
          lock_arm_o = !locked_i && byte_i[ARM_BIT];
          st_d       = ST_IGN;
        end
        default: ack_d = 1'b0;
      endcase
    end else if (rd_req_i && st_q == ST_RDAT) begin
      rd_fire_o = 1'b1;
      ptr_d     = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      ptr_q <= '0;
      ack_q <= 1'b0;
      a10_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ptr_q <= ptr_d;
      ack_q <= ack_d;
      a10_q <= a10_d;
    end
  end

  assign ack_o     = ack_q;
  assign ptr_o     = ptr_q;
  assign commit_o  = stop_i;
  assign drop_o    = start_i && !stop_i;
  assign sel_ph_o  = (st_q == ST_SEL);
  assign wdat_ph_o = (st_q == ST_WDAT);
endmodule

// File: rtl/idp_store.sv
module idp_store #(
  parameter int unsigned PAGE_BYTES = 128,
  parameter int unsigned DW         = 8,
  localparam int unsigned OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stg_we_i,
  input  logic [OFF_W-1:0] idx_i,
  input  logic [DW-1:0]    dat_i,
  input  logic             lock_arm_i,
  input  logic             commit_i,
  input  logic             drop_i,
  output logic [DW-1:0]    rd_dat_o,
  output logic             locked_o,
  output logic             work_o
);
  logic [PAGE_BYTES-1:0][DW-1:0] page_vec;
  logic [PAGE_BYTES-1:0]         stg_v_vec;
  logic                          lock_q, pend_q;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_byte
    logic [DW-1:0] page_q, stg_q;
    logic          vld_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        page_q <= '0;
        stg_q  <= '0;
        vld_q  <= 1'b0;
      end else if (commit_i) begin
        if (vld_q) page_q <= stg_q;
        vld_q <= 1'b0;
      end else if (drop_i) begin
        vld_q <= 1'b0;
      end else if (stg_we_i && idx_i == OFF_W'(g)) begin
        stg_q <= dat_i;
        vld_q <= 1'b1;
      end
    end
    assign page_vec[g]  = page_q;
    assign stg_v_vec[g] = vld_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      pend_q <= 1'b0;
    end else if (commit_i) begin
      lock_q <= lock_q | pend_q;
      pend_q <= 1'b0;
    end else if (drop_i) begin
      pend_q <= 1'b0;
    end else if (lock_arm_i) begin
      pend_q <= 1'b1;
    end
  end

  assign rd_dat_o = page_vec[idx_i];
  assign locked_o = lock_q;
  assign work_o   = (|stg_v_vec) | pend_q;
endmodule

// File: rtl/id_page_lock.sv
module id_page_lock #(
  parameter int unsigned PAGE_BYTES = 128,
  parameter int unsigned DW         = 8,
  localparam int unsigned OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    chip_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          byte_vld_i,
  input  logic [DW-1:0] byte_i,
  input  logic          rd_req_i,
  input  logic          prog_busy_i,
  output logic          ack_o,
  output logic [DW-1:0] rd_data_o,
  output logic          prog_start_o
);
  logic [OFF_W-1:0] ptr;
  logic             stg_we, lock_arm, commit, drop, rd_fire;
  logic             sel_ph, wdat_ph, locked, work;
  logic [DW-1:0]    page_byte;
  logic [DW-1:0]    rd_q;
  logic             prog_q;

  idp_ctrl #(.PAGE_BYTES(PAGE_BYTES), .DW(DW)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .chip_i     (chip_i),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .byte_vld_i (byte_vld_i),
    .byte_i     (byte_i),
    .rd_req_i   (rd_req_i),
    .busy_i     (prog_busy_i),
    .locked_i   (locked),
    .ack_o      (ack_o),
    .ptr_o      (ptr),
    .stg_we_o   (stg_we),
    .lock_arm_o (lock_arm),
    .commit_o   (commit),
    .drop_o     (drop),
    .rd_fire_o  (rd_fire),
    .sel_ph_o   (sel_ph),
    .wdat_ph_o  (wdat_ph)
  );

  idp_store #(.PAGE_BYTES(PAGE_BYTES), .DW(DW)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stg_we_i   (stg_we),
    .idx_i      (ptr),
    .dat_i      (byte_i),
    .lock_arm_i (lock_arm),
    .commit_i   (commit),
    .drop_i     (drop),
    .rd_dat_o   (page_byte),
    .locked_o   (locked),
    .work_o     (work)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= '0;
      prog_q <= 1'b0;
    end else begin
      if (rd_fire) rd_q <= page_byte;
      prog_q <= commit && work;
    end
  end

  assign rd_data_o    = rd_q;
  assign prog_start_o = prog_q;
endmodule

// File: rtl/idp_chk.sv
module idp_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic stop_i,
  input logic byte_vld_i,
  input logic prog_busy_i,
  input logic ack_o,
  input logic prog_start_o,
  input logic locked,
  input logic sel_ph,
  input logic wdat_ph,
  input logic stg_we,
  input logic commit
);
  p_busy_nack_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_i && sel_ph && prog_busy_i && !start_i && !stop_i |=> !ack_o);

  p_locked_nack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_i && wdat_ph && locked && !start_i && !stop_i |=> !ack_o);

  p_locked_nostage_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked |-> !stg_we);

  p_lock_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked |=> locked);

  p_lock_at_stop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked) |-> $past(commit));

  p_prog_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start_o |=> !prog_start_o);

  p_prog_after_stop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start_o |-> $past(stop_i));
endmodule

bind id_page_lock idp_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .stop_i       (stop_i),
  .byte_vld_i   (byte_vld_i),
  .prog_busy_i  (prog_busy_i),
  .ack_o        (ack_o),
  .prog_start_o (prog_start_o),
  .locked       (locked),
  .sel_ph       (sel_ph),
  .wdat_ph      (wdat_ph),
  .stg_we       (stg_we),
  .commit       (commit)
);

// File: tb/sim_id_page_lock.sv
`timescale 1ns/1ps
module sim_id_page_lock;
  localparam logic [1:0] OP_STA = 2'd0, OP_STO = 2'd1, OP_BYT = 2'd2, OP_RD = 2'd3;
  localparam int NV = 44;
  // {op, value, expected, requirement number}
  localparam logic [21:0] VEC [NV] = '{
    {OP_STA, 8'h00, 8'h00, 4'd0},
    {OP_BYT, 8'hBA, 8'h01, 4'd1},   // R1 select match
    {OP_BYT, 8'h00, 8'h01, 4'd3},   // R3 A10=0
    {OP_BYT, 8'h7E, 8'h01, 4'd3},   // offset 126
    {OP_BYT, 8'h11, 8'h01, 4'd3},
    {OP_BYT, 8'h22, 8'h01, 4'd3},
    {OP_BYT, 8'h33, 8'h01, 4'd3},   // wraps to 0
    {OP_STO, 8'h00, 8'h01, 4'd3},   // prog pulse
    {OP_STA, 8'h00, 8'h00, 4'd0},
    {OP_BYT, 8'hBA, 8'h01, 4'd10},
    {OP_BYT, 8'hFB, 8'h01, 4'd10},  // high bits ignored, A10=0
    {OP_BYT, 8'hFE, 8'h01, 4'd10},  // bit7 ignored -> 126
    {OP_STA, 8'h00, 8'h00, 4'd0},
    {OP_BYT, 8'hBB, 8'h01, 4'd10},  // R10 random read
    {OP_RD,  8'h00, 8'h11, 4'd10},
    {OP_RD,  8'h00, 8'h22, 4'd10},
    {OP_RD,  8'h00, 8'h33, 4'd10},  // wrap read
    {OP_STO, 8'h00, 8'h00, 4'd10},
    {OP_STA, 8'h00, 8'h00, 4'd0},
    {OP_BYT, 8'hBB, 8'h01, 4'd10},  // current read at 1
    {OP_RD,  8'h00, 8'h00, 4'd10},
    {OP_STO, 8'h00, 8'h00, 4'd10},
    {OP_STA, 8'h00, 8'h00, 4'd0},
    {OP_BYT, 8'hAA, 8'h00, 4'd1},   // R1 other device code
    {OP_BYT, 8'h00, 8'h00, 4'd1},
    {OP_STO, 8'h00, 8'h00, 4'd1},
    {OP_STA, 8'h00, 8'h00, 4'd0},
    {OP_BYT, 8'hB4, 8'h00, 4'd1},   // R1 other chip
    {OP_BYT, 8'h00, 8'h00, 4'd1},
    {OP_STO, 8'h00, 8'h00, 4'd1},
    {OP_STA, 8'h00, 8'h00, 4'd0},
    {OP_BYT, 8'hBA, 8'h01, 4'd4},   // R4 aborted write
    {OP_BYT, 8'h00, 8'h01, 4'd4},
    {OP_BYT, 8'h05, 8'h01, 4'd4},
    {OP_BYT, 8'h55, 8'h01, 4'd4},
    {OP_STA, 8'h00, 8'h00, 4'd0},
    {OP_BYT, 8'hBA, 8'h01, 4'd4},
    {OP_BYT, 8'h00, 8'h01, 4'd4},
    {OP_BYT, 8'h05, 8'h01, 4'd4},
    {OP_STA, 8'h00, 8'h00, 4'd0},
    {OP_BYT, 8'hBB, 8'h01, 4'd4},
    {OP_RD,  8'h00, 8'h00, 4'd4},   // staged 0x55 discarded
    {OP_STO, 8'h00, 8'h00, 4'd4},   // no prog pulse
    {OP_STA, 8'h00, 8'h00, 4'd0}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] chip_i = 3'b101;
  logic       start_i = 1'b0, stop_i = 1'b0, byte_vld_i = 1'b0, rd_req_i = 1'b0;
  logic       prog_busy_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic       ack_o, prog_start_o;
  logic [7:0] rd_data_o;
  int         total = 0, bad = 0;

  always #2 clk_i = ~clk_i;

  id_page_lock u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .chip_i(chip_i), .start_i(start_i), .stop_i(stop_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .rd_req_i(rd_req_i), .prog_busy_i(prog_busy_i),
    .ack_o(ack_o), .rd_data_o(rd_data_o), .prog_start_o(prog_start_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_start();
    start_i = 1'b1; @(negedge clk_i); start_i = 1'b0;
  endtask
  task automatic do_stop(input string req, input bit exp);
    stop_i = 1'b1; @(negedge clk_i); stop_i = 1'b0;
    chk(prog_start_o == exp, req, int'(prog_start_o), int'(exp));
    @(negedge clk_i);
  endtask
  task automatic do_byte(input logic [7:0] b, input string req, input bit exp);
    byte_i = b; byte_vld_i = 1'b1; @(negedge clk_i); byte_vld_i = 1'b0;
    chk(ack_o == exp, req, int'(ack_o), int'(exp));
  endtask
  task automatic do_rd(input string req, input logic [7:0] exp);
    rd_req_i = 1'b1; @(negedge clk_i); rd_req_i = 1'b0;
    chk(rd_data_o == exp, req, int'(rd_data_o), int'(exp));
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R11 reset state
    chk(ack_o == 1'b0, "R11 ack", int'(ack_o), 0);
    chk(prog_start_o == 1'b0, "R11 prog", int'(prog_start_o), 0);
    chk(rd_data_o == 8'h00, "R11 rdata", int'(rd_data_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      automatic logic [1:0] op  = VEC[i][21:20];
      automatic logic [7:0] val = VEC[i][19:12];
      automatic logic [7:0] exv = VEC[i][11:4];
      automatic string req = $sformatf("R%0d vec%0d", VEC[i][3:0], i);
      case (op)
        OP_STA: do_start();
        OP_STO: do_stop(req, exv[0]);
        OP_BYT: do_byte(val, req, exv[0]);
        default: do_rd(req, exv);
      endcase
    end
    do_stop("R4 idle stop", 1'b0);

    // R2 busy timer refuses select
    prog_busy_i = 1'b1;
    do_start(); do_byte(8'hBA, "R2 busy select", 1'b0);
    do_byte(8'h00, "R2 rest ignored", 1'b0);
    do_stop("R2 stop", 1'b0);
    prog_busy_i = 1'b0;

    // R6 lock data with bit1 clear
    do_start(); do_byte(8'hBA, "R6 sel", 1'b1); do_byte(8'h04, "R6 a10", 1'b1);
    do_byte(8'h00, "R6 alo", 1'b1); do_byte(8'hFD, "R6 data ack", 1'b1);
    do_stop("R6 no prog", 1'b0);

    // R8 probe unlocked, then cancelled by start
    do_start(); do_byte(8'hBA, "R8 sel", 1'b1); do_byte(8'h04, "R8 a10", 1'b1);
    do_byte(8'h00, "R8 alo", 1'b1); do_byte(8'h02, "R8 probe unlocked", 1'b1);
    do_start(); do_stop("R8 probe cancelled", 1'b0);

    // R8 cancelled probe must not lock: still writable
    do_start(); do_byte(8'hBA, "R8 sel2", 1'b1); do_byte(8'h00, "R8 ahi", 1'b1);
    do_byte(8'h20, "R8 alo2", 1'b1); do_byte(8'h5A, "R8 still unlocked", 1'b1);
    do_stop("R8 write prog", 1'b1);

    // R5 real lock
    do_start(); do_byte(8'hBA, "R5 sel", 1'b1); do_byte(8'hFF, "R5 a10", 1'b1);
    do_byte(8'h00, "R5 alo", 1'b1); do_byte(8'h02, "R5 lock data", 1'b1);
    do_stop("R5 prog", 1'b1);

    // R8 probe locked
    do_start(); do_byte(8'hBA, "R8 sel3", 1'b1); do_byte(8'h04, "R8 a10b", 1'b1);
    do_byte(8'h00, "R8 alo3", 1'b1); do_byte(8'h00, "R8 probe locked", 1'b0);
    do_start(); do_stop("R8 stop", 1'b0);

    // R7 write refused while locked
    do_start(); do_byte(8'hBA, "R7 sel", 1'b1); do_byte(8'h00, "R7 ahi", 1'b1);
    do_byte(8'h20, "R7 alo", 1'b1); do_byte(8'h99, "R7 data nack", 1'b0);
    do_byte(8'h98, "R7 data nack2", 1'b0);
    do_stop("R7 no prog", 1'b0);
    do_start(); do_byte(8'hBA, "R7 sel2", 1'b1); do_byte(8'h00, "R7 ahi2", 1'b1);
    do_byte(8'h20, "R7 alo2", 1'b1); do_start(); do_byte(8'hBB, "R7 rsel", 1'b1);
    do_rd("R7 page kept", 8'h5A);
    do_stop("R7 stop", 1'b0);

    // R9 lock survives further lock traffic
    do_start(); do_byte(8'hBA, "R9 sel", 1'b1); do_byte(8'h04, "R9 a10", 1'b1);
    do_byte(8'h00, "R9 alo", 1'b1); do_byte(8'hFD, "R9 still locked", 1'b0);
    do_stop("R9 stop", 1'b0);

    // R9 only reset clears lock; R11 page cleared
    @(negedge clk_i); rst_ni = 1'b0; @(negedge clk_i); rst_ni = 1'b1; @(negedge clk_i);
    do_start(); do_byte(8'hBA, "R9 sel2", 1'b1); do_byte(8'h04, "R9 a10b", 1'b1);
    do_byte(8'h00, "R9 alo2", 1'b1); do_byte(8'h00, "R9 unlocked after reset", 1'b1);
    do_start(); do_stop("R9 stop2", 1'b0);
    do_start(); do_byte(8'hBA, "R11 sel", 1'b1); do_byte(8'h00, "R11 ahi", 1'b1);
    do_byte(8'h20, "R11 alo", 1'b1); do_start(); do_byte(8'hBB, "R11 rsel", 1'b1);
    do_rd("R11 page cleared", 8'h00);
    do_stop("R11 stop", 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule